// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines a global history of recent branch outcomes with a table of small saturating counters. A shift register holds the last few resolved outcomes of all branches, with 1 meaning taken. That history is merged with the low-order bits of a branch address to select one counter. The top bit of the selected counter gives the guess.

There are two ways to form the index, chosen by a parameter. In correlating mode the address bits are placed above the history bits, so the address picks a row of counters and the history picks one counter within that row. In hashed mode the address bits are XORed with the zero-extended history.

The fetch side presents an address and receives a combinational prediction, together with the history value that produced it. The execute side later returns the branch address, that saved history and the resolved outcome. The update trains the counter the prediction actually used, then shifts the outcome into the history. Entries have no tags, so branches that share an index share a counter.

Top module: `gcorr_predictor`

## Requirements
- R1: After reset the history register is all zeros and every counter holds 2^(CTR_BITS-1)-1, so every address predicts not taken and `pred_hist` reads 0.
- R2: Each cycle with `upd_valid` high shifts the history left by one, puts `upd_taken` in bit 0 and drops the oldest bit. Without an update the history holds. `pred_hist` always shows the current history.
- R3: With `XOR_HASH`=0 the counter index is {address[ADDR_BITS-1:0], history}, with the history in the low bits.
- R4: With `XOR_HASH`=1 the counter index is address[ADDR_BITS-1:0] XOR the zero-extended history.
- R5: A taken update raises the indexed counter by one, stopping at 2^CTR_BITS-1.
- R6: A not-taken update lowers the indexed counter by one, stopping at 0.
- R7: `pred_taken` is 1 exactly when the selected counter is at least 2^(CTR_BITS-1).
- R8: The update index is formed from `upd_hist`, not from the current history register.
- R9: A prediction made in the same cycle as an update to the same counter reflects the counter value before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_addr | input | ADDR_BITS | Low-order bits of the branch address being fetched |
| pred_taken | output | 1 | Predicted direction, 1 for taken |
| pred_hist | output | HIST_BITS | History value used for this prediction |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_addr | input | ADDR_BITS | Low-order address bits of the resolved branch |
| upd_hist | input | HIST_BITS | History captured when that branch was predicted |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |

## Verification
A corrupted counter shows up as a wrong `pred_taken`. That happens only once the address and the current history select the counter again, and only if the corruption moves it across the midpoint. For this reason the bench re-reads every address after each update. A history fault shows up on `pred_hist` right after the update that caused it, and it shifts the whole prediction map in the same cycle. Two instances are swept, one per hash mode, with different counter widths. A model in the bench checks them across directed saturation runs, a loop pattern, and random updates whose returned history often differs from the live one.

// File: rtl/gcorr_predictor.sv
module gcorr_predictor #(
  parameter int ADDR_BITS = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter bit XOR_HASH  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_BITS-1:0] pred_addr,
  output logic                 pred_taken,
  output logic [HIST_BITS-1:0] pred_hist,
  input  logic                 upd_valid,
  input  logic [ADDR_BITS-1:0] upd_addr,
  input  logic [HIST_BITS-1:0] upd_hist,
  input  logic                 upd_taken
);
  localparam int IDX_W   = XOR_HASH ? ADDR_BITS : ADDR_BITS + HIST_BITS;
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_BITS-1:0] CTR_MAX  = {CTR_BITS{1'b1}};
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);

  logic [HIST_BITS-1:0] ghr;
  logic [CTR_BITS-1:0]  ctr [ENTRIES];
  logic [IDX_W-1:0]     p_idx, u_idx;

  generate
    if (XOR_HASH) begin : g_xor
      assign p_idx = pred_addr ^ ADDR_BITS'(ghr);
      assign u_idx = upd_addr ^ ADDR_BITS'(upd_hist);
    end else begin : g_cat
      assign p_idx = {pred_addr, ghr};
      assign u_idx = {upd_addr, upd_hist};
    end
  endgenerate

  assign pred_taken = ctr[p_idx][CTR_BITS-1];
  assign pred_hist  = ghr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr <= '0;
      for (int i = 0; i < ENTRIES; i++) ctr[i] <= CTR_INIT;
    end else if (upd_valid) begin
      ghr <= HIST_BITS'({ghr, upd_taken});
      if (upd_taken && ctr[u_idx] != CTR_MAX)
        ctr[u_idx] <= ctr[u_idx] + 1'b1;
      else if (!upd_taken && ctr[u_idx] != '0)
        ctr[u_idx] <= ctr[u_idx] - 1'b1;
    end
  end

  a_r2_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_hist == HIST_BITS'({$past(pred_hist), $past(upd_taken)}));
  a_r2_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));
  a_r5_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr[u_idx] != CTR_MAX)
      |=> ctr[$past(u_idx)] == CTR_BITS'($past(ctr[u_idx]) + 1'b1));
  a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr[u_idx] == CTR_MAX) |=> ctr[$past(u_idx)] == CTR_MAX);
  a_r6_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr[u_idx] != '0)
      |=> ctr[$past(u_idx)] == CTR_BITS'($past(ctr[u_idx]) - 1'b1));
  a_r6_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr[u_idx] == '0) |=> ctr[$past(u_idx)] == '0);
endmodule

// File: tb/gcorr_predictor_tb.sv
module gcorr_predictor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pa = '0, ua = '0;
  logic uv = 1'b0, ut = 1'b0;
  logic [1:0] uh_a = '0;
  logic [2:0] uh_b = '0;
  logic pt_a, pt_b;
  logic [1:0] ph_a;
  logic [2:0] ph_b;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int ma [64];
  int mb [16];
  int ga = 0, gb = 0;

  always #2.5 clk = ~clk;

  gcorr_predictor #(.ADDR_BITS(4), .HIST_BITS(2), .CTR_BITS(2), .XOR_HASH(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_addr(pa), .pred_taken(pt_a), .pred_hist(ph_a),
    .upd_valid(uv), .upd_addr(ua), .upd_hist(uh_a), .upd_taken(ut));

  gcorr_predictor #(.ADDR_BITS(4), .HIST_BITS(3), .CTR_BITS(3), .XOR_HASH(1'b1)) u_dut_xor (
    .clk(clk), .rst_n(rst_n), .pred_addr(pa), .pred_taken(pt_b), .pred_hist(ph_b),
    .upd_valid(uv), .upd_addr(ua), .upd_hist(uh_b), .upd_taken(ut));

  function automatic int idx_a(int a, int h); return a * 4 + h; endfunction
  function automatic int idx_b(int a, int h); return a ^ h; endfunction

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // R3 R4 R7 R2: full address sweep at the current history
  task automatic sweep();
    for (int a = 0; a < 16; a++) begin
      pa = 4'(a);
      #1;
      check("R3 R7 cat-mode prediction", int'(pt_a), int'(ma[idx_a(a, ga)] >= 2));
      check("R4 R7 xor-mode prediction", int'(pt_b), int'(mb[idx_b(a, gb)] >= 4));
    end
    check("R2 history cat", int'(ph_a), ga);
    check("R2 history xor", int'(ph_b), gb);
  endtask

  task automatic upd(int a, bit t, bit stale);
    int ha, hb;
    @(negedge clk);
    ha = stale ? int'($urandom_range(0, 3)) : ga;
    hb = stale ? int'($urandom_range(0, 7)) : gb;
    ua = 4'(a); ut = t; uh_a = 2'(ha); uh_b = 3'(hb); uv = 1'b1;
    // R9: same-cycle prediction shows the counter before this update
    pa = 4'(a);
    #1;
    check("R9 pre-update read cat", int'(pt_a), int'(ma[idx_a(a, ga)] >= 2));
    check("R9 pre-update read xor", int'(pt_b), int'(mb[idx_b(a, gb)] >= 4));
    @(posedge clk);
    #1;
    uv = 1'b0;
    // R5 R6 R8: model trains the entry named by the returned history
    if (t) begin
      if (ma[idx_a(a, ha)] < 3) ma[idx_a(a, ha)]++;
      if (mb[idx_b(a, hb)] < 7) mb[idx_b(a, hb)]++;
    end else begin
      if (ma[idx_a(a, ha)] > 0) ma[idx_a(a, ha)]--;
      if (mb[idx_b(a, hb)] > 0) mb[idx_b(a, hb)]--;
    end
    ga = ((ga << 1) | int'(t)) & 3;
    gb = ((gb << 1) | int'(t)) & 7;
    sweep();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ma[i] = 1;
    for (int i = 0; i < 16; i++) mb[i] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, all not taken, history zero
    for (int a = 0; a < 16; a++) begin
      pa = 4'(a);
      #1;
      check("R1 reset cat", int'(pt_a), 0);
      check("R1 reset xor", int'(pt_b), 0);
    end
    check("R1 reset hist cat", int'(ph_a), 0);
    check("R1 reset hist xor", int'(ph_b), 0);
    // R5: drive one branch into top saturation
    for (int k = 0; k < 10; k++) upd(5, 1'b1, 1'b0);
    // R6: then drive it to the floor
    for (int k = 0; k < 12; k++) upd(5, 1'b0, 1'b0);
    // loop pattern: nine taken, one exit
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 9; k++) upd(9, 1'b1, 1'b0);
      upd(9, 1'b0, 1'b0);
    end
    // R8: random traffic, returned history often differs from live one
    for (int k = 0; k < 300; k++)
      upd(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    // R2: idle cycles leave history and predictions unchanged
    repeat (4) @(negedge clk);
    sweep();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule